// File: doc/BRIEF.md
# I2C Target with Selectable Clock-Stretch Point

This block is the target (slave) side of an I2C bus. It watches the two open-drain lines and detects start and stop conditions. It compares the first byte after a start against a programmable 7-bit address, then shifts data bytes in or out, most significant bit first. At one chosen point in every byte it stretches the clock by holding SCL low. A local host uses that pause to read a received byte, load the next byte to transmit, or decide how to acknowledge. The host then lets the transfer continue.

The stall point is set by the host. With the first setting the stall falls after the eighth clock, before the acknowledge bit. With the second it falls after the ninth clock, once the acknowledge has been exchanged. A one-cycle interrupt pulse marks each stall and each stop condition.

There are two ways to end a stall. While transmitting, the host writes the next byte into the data register. While receiving, the host writes any value (by convention FFH) to the data register or sets the release bit. If the release bit is used during a transmit stall, the block leaves transmit mode: it clears the direction flag and lets SDA go for the rest of the transfer.

SDA and SCL are modelled as a sampled input plus an active-high pull-low enable. The block resolves nothing on the bus itself.

Top module: `i2c_tgt_wait`

## Requirements
- R1: A falling SDA while SCL is high is a start condition. It sets the start flag (status register 3, bit 1), clears the stop flag, and makes the next byte an address byte.
- R2: A rising SDA while SCL is high is a stop condition. It sets the stop flag (register 3, bit 2), clears the start flag, returns the block to idle and gives one interrupt pulse.
- R3: An address byte matches when its upper seven bits equal the own-address register (register 2, bits 6:0). On a match the target pulls SDA low on the ninth clock. On a mismatch it never pulls SDA, never stalls and gives no interrupt until the next start.
- R4: After a matching address, the direction flag (register 3, bit 0) equals bit 0 of the address byte: 1 means the target transmits.
- R5: Control register 1, bit 2 picks the stall point: 0 stalls after the falling edge of the eighth clock, 1 after the falling edge of the ninth. Each stall holds SCL low (status bit 4 set) and gives exactly one one-cycle interrupt pulse, and no other clock of the byte stalls.
- R6: A received byte is shifted in MSB first and can be read at register 0 during the stall that follows it.
- R7: For a received data byte, control bit 1 (acknowledge enable) chooses ACK (SDA low) when 1 and NACK (SDA released) when 0 on the ninth clock. The bit may be changed during an eighth-clock stall.
- R8: A write to register 0 loads the byte and ends a pending stall. In transmit mode that byte is driven onto SDA MSB first over the next eight clocks.
- R9: After each transmitted byte, the acknowledge-detected flag (register 3, bit 3) is 1 when the receiver held SDA low on the ninth clock and 0 otherwise.
- R10: Writing 1 to control bit 0 ends a pending stall. If the target was transmitting, the direction flag clears and SDA stays released until the next start or stop.
- R11: After the receiver NACKs a transmitted byte, the target releases SDA and ignores all further clocks, with no stall and no interrupt, until the next start or stop.
- R12: After reset neither line is pulled, the interrupt is low, all flags are 0, the control bits are 0, and the own address is the parameter value.
- R13: The SDA pull enable never changes while SCL has been high for several cycles, so the target never creates a start or stop of its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| scl_oe | output | 1 | Pull SCL low (clock stretch) when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register select (0 data, 1 control, 2 own address, 3 status) |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for the selected register, combinational |
| irq | output | 1 | One-cycle pulse at each stall and at each stop |

## Verification
Bus inputs pass through two synchronising flops before an edge is recognised. A stall and its interrupt therefore appear three or four cycles after the bench pulls SCL low. The bench checks for them twelve cycles after that falling edge, and it checks that SCL is released two cycles after the releasing register write.

Acknowledge and data bits that the target drives are sampled in the middle of a ten-cycle SCL-high window. Flags are read one cycle after they are due. On every clock, a monitor compares SDA drive against the rule that it stays still while SCL is high, and checks that interrupts last exactly one cycle.

// File: rtl/i2c_tgt_wait.sv
module i2c_tgt_wait #(
  parameter logic [6:0] RST_OWN_ADDR = 7'h2A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_IGN} st_t;

  st_t        st;
  logic       scl_m, scl_s, scl_q, sda_m, sda_s, sda_q;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [6:0] own;
  logic       hold, trc, drv, ack_det, f_start, f_stop, ack_en, wait9;

  logic start_ev, stop_ev, rise, fall, live, match, tx, wpt;
  logic wr_dat, wr_ctl, wr_own;

  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise     = scl_s & ~scl_q;
  assign fall     = ~scl_s & scl_q;
  assign live     = (st == S_ADDR) || (st == S_DATA);
  assign match    = (sh[7:1] == own);
  assign tx       = (st == S_DATA) && trc;
  assign wpt      = wait9 ? (cnt == 4'd9) : (cnt == 4'd8);
  assign wr_dat   = reg_we && (reg_addr == 2'd0);
  assign wr_ctl   = reg_we && (reg_addr == 2'd1);
  assign wr_own   = reg_we && (reg_addr == 2'd2);

  assign scl_oe = hold;
  assign sda_oe = drv;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = sh;
      2'd1:    reg_rdata = {5'd0, wait9, ack_en, 1'b0};
      2'd2:    reg_rdata = {1'b0, own};
      default: reg_rdata = {3'd0, hold, ack_det, f_stop, f_start, trc};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_q <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_q <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= 4'd0;
      sh      <= 8'd0;
      own     <= RST_OWN_ADDR;
      hold    <= 1'b0;
      trc     <= 1'b0;
      drv     <= 1'b0;
      ack_det <= 1'b0;
      f_start <= 1'b0;
      f_stop  <= 1'b0;
      ack_en  <= 1'b0;
      wait9   <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (start_ev) begin
        st <= S_ADDR; cnt <= 4'd0; hold <= 1'b0; trc <= 1'b0; drv <= 1'b0;
        f_start <= 1'b1; f_stop <= 1'b0;
      end else if (stop_ev) begin
        st <= S_IDLE; cnt <= 4'd0; hold <= 1'b0; trc <= 1'b0; drv <= 1'b0;
        f_stop <= 1'b1; f_start <= 1'b0; irq <= 1'b1;
      end else begin
        if (rise && live && cnt != 4'd9) begin
          cnt <= cnt + 4'd1;
          if (cnt < 4'd8 && !tx) sh <= {sh[6:0], sda_s};
          if (cnt == 4'd8 && tx) ack_det <= ~sda_s;
        end

        if (fall && live) begin
          if (st == S_ADDR && cnt == 4'd8 && !match) begin
            st  <= S_IGN;
            drv <= 1'b0;
          end else begin
            if (cnt == 4'd9) begin
              cnt <= 4'd0;
              if (st == S_ADDR) begin
                st  <= S_DATA;
                drv <= trc & ~sh[7];
              end else if (trc && !ack_det) begin
                st  <= S_IGN;
                drv <= 1'b0;
              end else begin
                drv <= trc & ~sh[7];
              end
            end else if (cnt == 4'd8) begin
              if (st == S_ADDR) begin
                trc <= sh[0];
                drv <= 1'b1;
              end else begin
                drv <= ~trc & ack_en;
              end
            end else if (tx && cnt != 4'd0) begin
              sh  <= {sh[6:0], 1'b0};
              drv <= ~sh[6];
            end
            if (wpt) begin
              hold <= 1'b1;
              irq  <= 1'b1;
            end
          end
        end

        if (wr_dat) begin
          sh <= reg_wdata;
          if (hold) begin
            hold <= 1'b0;
            if (tx && cnt == 4'd0) drv <= ~reg_wdata[7];
          end
        end

        if (wr_ctl) begin
          ack_en <= reg_wdata[1];
          wait9  <= reg_wdata[2];
          if (hold && st == S_DATA && !trc && cnt == 4'd8) drv <= reg_wdata[1];
          if (reg_wdata[0] && hold) begin
            hold <= 1'b0;
            if (trc) begin
              trc <= 1'b0;
              st  <= S_IGN;
              drv <= 1'b0;
            end
          end
        end

        if (wr_own) own <= reg_wdata[6:0];
      end
    end
  end

endmodule

// File: rtl/i2c_tgt_wait_chk.sv
module i2c_tgt_wait_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       irq,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic       rel_bit,
  input logic       hold,
  input logic       trc,
  input logic [1:0] st_q
);

  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_stall_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> irq);

  p_sda_still_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)) |-> $stable(sda_oe));

  p_rel_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd1 && rel_bit && hold) |=> (!hold && !trc));

  p_data_rel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0 && hold) |=> !hold);

  p_ign_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 2'd3) |-> !sda_oe);

  p_idle_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 2'd0) |-> !trc);

  p_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!scl_oe && !sda_oe && !irq));

endmodule

bind i2c_tgt_wait i2c_tgt_wait_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .irq(irq), .reg_we(reg_we), .reg_addr(reg_addr), .rel_bit(reg_wdata[0]),
  .hold(hold), .trc(trc), .st_q(st)
);

// File: tb/i2c_tgt_wait_tb_top.sv
module i2c_tgt_wait_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       scl_oe, sda_oe, irq;
  logic       scl_bus, sda_bus;

  int tests = 0;
  int fails = 0;
  int irq_cnt = 0;
  int irq_exp = 0;
  int mon_err = 0;
  int mon_cyc = 0;

  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_tgt_wait dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // per-clock reference: SDA drive still while SCL high (R13), single-cycle irq (R5)
  logic [2:0] scl_hist = 3'b111;
  logic       oe_prev = 1'b0;
  logic       irq_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      mon_cyc++;
      if (scl_bus && (&scl_hist) && (sda_oe !== oe_prev)) mon_err++;
      if (irq && irq_prev) mon_err++;
      if (irq) irq_cnt++;
    end
    scl_hist = {scl_hist[1:0], scl_bus};
    oe_prev  = sda_oe;
    irq_prev = irq;
  end

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(10);
    scl_m = 1'b1;
    do @(negedge clk); while (!scl_bus);
    tick(10);
    sda_m = 1'b0; tick(10);
    scl_m = 1'b0; tick(12);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(10);
    scl_m = 1'b1;
    do @(negedge clk); while (!scl_bus);
    tick(10);
    sda_m = 1'b1; tick(12);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; tick(10);
    scl_m = 1'b1;
    do @(negedge clk); while (!scl_bus);
    tick(5);
    s = sda_bus;
    tick(5);
    scl_m = 1'b0; tick(12);
  endtask

  task automatic send8(input logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
  endtask

  task automatic recv8(output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
  endtask

  task automatic expect_wait(input logic exp, input string req);
    chk(req, "stall (scl_oe)", scl_oe, exp);
    if (exp) irq_exp++;
    chk(req, "interrupt count", irq_cnt, irq_exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    logic [7:0] v;
    logic       s;

    tick(3);
    chk("R12", "scl_oe in reset", scl_oe, 0);
    chk("R12", "sda_oe in reset", sda_oe, 0);
    chk("R12", "irq in reset", irq, 0);
    rst_n = 1'b1;
    tick(3);
    reg_rd(2'd2, v); chk("R12", "own address", v, 8'h2A);
    reg_rd(2'd3, v); chk("R12", "status", v, 8'h00);
    reg_rd(2'd1, v); chk("R12", "control", v, 8'h00);

    reg_wr(2'd2, 8'h35);
    reg_wr(2'd1, 8'h02);

    // receive, stall after 8th clock
    bus_start;
    reg_rd(2'd3, v); chk("R1", "status after start", v, 8'h02);
    send8(8'h6A);
    expect_wait(1'b1, "R5");
    reg_rd(2'd3, v); chk("R4", "status in address stall", v, 8'h12);
    reg_wr(2'd1, 8'h03);
    tick(2);
    chk("R10", "scl released", scl_oe, 0);
    clk_bit(1'b1, s); chk("R3", "address ack", s, 0);
    expect_wait(1'b0, "R5");
    send8(8'hA5);
    expect_wait(1'b1, "R5");
    reg_rd(2'd0, v); chk("R6", "received byte", v, 8'hA5);
    reg_wr(2'd0, 8'hFF);
    tick(2);
    chk("R8", "scl released by data write", scl_oe, 0);
    clk_bit(1'b1, s); chk("R7", "ack with enable", s, 0);
    expect_wait(1'b0, "R5");
    send8(8'h3C);
    expect_wait(1'b1, "R5");
    reg_rd(2'd0, v); chk("R6", "received byte 2", v, 8'h3C);
    reg_wr(2'd1, 8'h01);
    clk_bit(1'b1, s); chk("R7", "nack without enable", s, 1);
    bus_stop;
    irq_exp++;
    chk("R2", "stop interrupt", irq_cnt, irq_exp);
    reg_rd(2'd3, v); chk("R2", "status after stop", v, 8'h04);

    // receive, stall after 9th clock
    reg_wr(2'd1, 8'h06);
    bus_start;
    send8(8'h6A);
    expect_wait(1'b0, "R5");
    clk_bit(1'b1, s); chk("R3", "address ack 9-clock", s, 0);
    expect_wait(1'b1, "R5");
    reg_wr(2'd1, 8'h07);
    send8(8'h5A);
    expect_wait(1'b0, "R5");
    clk_bit(1'b1, s); chk("R7", "ack 9-clock", s, 0);
    expect_wait(1'b1, "R5");
    reg_rd(2'd0, v); chk("R6", "received byte 9-clock", v, 8'h5A);
    reg_wr(2'd1, 8'h07);
    bus_stop;
    irq_exp++;
    chk("R2", "stop interrupt 2", irq_cnt, irq_exp);

    // transmit, stall after 9th clock, ends in NACK
    bus_start;
    send8(8'h6B);
    expect_wait(1'b0, "R5");
    clk_bit(1'b1, s); chk("R3", "read address ack", s, 0);
    expect_wait(1'b1, "R5");
    reg_rd(2'd3, v); chk("R4", "direction flag", v & 8'h01, 1);
    reg_wr(2'd0, 8'hC3);
    tick(2);
    chk("R8", "scl released by load", scl_oe, 0);
    recv8(v); chk("R8", "transmitted byte", v, 8'hC3);
    expect_wait(1'b0, "R5");
    clk_bit(1'b0, s);
    expect_wait(1'b1, "R5");
    reg_rd(2'd3, v); chk("R9", "ack detected", (v >> 3) & 1, 1);
    reg_wr(2'd0, 8'h81);
    recv8(v); chk("R8", "transmitted byte 2", v, 8'h81);
    expect_wait(1'b0, "R5");
    clk_bit(1'b1, s);
    expect_wait(1'b1, "R5");
    reg_rd(2'd3, v); chk("R9", "nack detected", (v >> 3) & 1, 0);
    reg_wr(2'd1, 8'h07);
    reg_rd(2'd3, v); chk("R10", "direction cleared", v & 8'h01, 0);
    recv8(v); chk("R11", "released after nack", v, 8'hFF);
    expect_wait(1'b0, "R11");
    clk_bit(1'b1, s);
    expect_wait(1'b0, "R11");
    bus_stop;
    irq_exp++;
    chk("R2", "stop interrupt 3", irq_cnt, irq_exp);

    // transmit, stall after 8th clock, release bit ends transmit
    reg_wr(2'd1, 8'h02);
    bus_start;
    send8(8'h6B);
    expect_wait(1'b1, "R5");
    reg_rd(2'd3, v); chk("R4", "direction in 8-clock stall", v & 8'h01, 1);
    reg_wr(2'd0, 8'h96);
    clk_bit(1'b1, s); chk("R3", "read address ack 8-clock", s, 0);
    expect_wait(1'b0, "R5");
    recv8(v); chk("R8", "transmitted byte 8-clock", v, 8'h96);
    expect_wait(1'b1, "R5");
    reg_wr(2'd1, 8'h03);
    reg_rd(2'd3, v); chk("R10", "status after release bit", v & 8'h11, 0);
    clk_bit(1'b0, s);
    expect_wait(1'b0, "R10");
    recv8(v); chk("R10", "sda released after release bit", v, 8'hFF);
    expect_wait(1'b0, "R10");
    clk_bit(1'b1, s);
    bus_stop;
    irq_exp++;
    chk("R2", "stop interrupt 4", irq_cnt, irq_exp);

    // address mismatch
    bus_start;
    send8(8'h24);
    expect_wait(1'b0, "R3");
    clk_bit(1'b1, s); chk("R3", "no ack on mismatch", s, 1);
    expect_wait(1'b0, "R3");
    send8(8'h00);
    expect_wait(1'b0, "R3");
    clk_bit(1'b1, s); chk("R3", "no ack after mismatch", s, 1);
    bus_stop;
    irq_exp++;
    chk("R2", "stop interrupt 5", irq_cnt, irq_exp);
    reg_rd(2'd3, v); chk("R2", "final status", v, 8'h04);

    tick(5);
    chk("R13", "per-clock monitor mismatches", mon_err, 0);
    report();
  end

endmodule